// File: doc/BRIEF.md
# Debug Receive Mailbox

This block holds one data word passed from an external debug host to an on-chip debug handler. The host writes a word together with a valid qualifier and an optional download qualifier. The core reads the word through its own port. Both sides watch a small set of status flags: ready (an unread word is waiting), download (a streaming transfer is in progress) and overflow (an unread word was lost). Everything runs on one clock. The scan chain and any clock-domain crossing sit outside this block.

In the polled mode, the host waits until ready is clear before it writes, and the core waits until ready is set before it reads. A read clears ready. In the streaming mode, the host marks its writes as downloads and sends words back to back without polling. The core keeps reading while the download flag stays set. If a write lands on a word that has not been read, the new word replaces it and a sticky overflow flag records the loss. The host ends a stream by pulsing its download-clear strobe.

Top module: `dbg_rx_mailbox`

## Requirements
- R1: A host write with `host_valid` high, made while ready is clear, stores `host_wdata` and sets ready. Both are visible one cycle later.
- R2: A core read (`core_rd` high) with no accepted write in the same cycle clears ready one cycle later. `core_rdata` always shows the stored word combinationally.
- R3: A host write strobe with `host_valid` low changes no flag and no data.
- R4: In polled mode, a write made while ready is set and no read is made in the same cycle is dropped. Polled mode means the stored download flag is clear and the write's `host_dl` is low. The stored word is kept and overflow does not change.
- R5: A valid write with `host_dl` high sets the download flag. The flag stays set until `host_dl_clr` is pulsed. If a clear and a setting write come in the same cycle, the clear wins.
- R6: In streaming mode, a write made while ready is set and no read is made in the same cycle overwrites the stored word and sets overflow. Streaming mode means the stored download flag is set or the write's `host_dl` is high.
- R7: Overflow is sticky and clears only on `core_ovf_clr`. If a new overflow and a clear come in the same cycle, overflow stays set.
- R8: When a core read and a valid write come in the same cycle, the read returns the old word, the new word is stored, ready stays set and no overflow is raised.
- R9: `host_status` and `core_status` share one layout: bit 0 is ready, bit 1 is download, bit 2 is overflow. After reset all flags and the data word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_valid | input | 1 | Host write carries a valid word |
| host_dl | input | 1 | Host write belongs to a streaming download |
| host_wdata | input | DATA_W | Host write data |
| host_dl_clr | input | 1 | Host strobe that clears the download flag |
| host_status | output | 3 | Host view of the flags |
| core_rd | input | 1 | Core read strobe, consumes the word |
| core_rdata | output | DATA_W | Stored word |
| core_status | output | 3 | Core view of the flags |
| core_ovf_clr | input | 1 | Core strobe that clears overflow |

## Verification
The assertions accept any combination of strobes in any cycle. They assume only that every input is driven to a known level once reset is released, and each property excludes the strobes that would legally override the flag it checks. The stimulus drives inputs half a cycle away from the active edge and always drives a full value on every input. Directed sequences cover each mode and each same-cycle collision. A stretch of unconstrained random strobes, compared cycle by cycle against a behavioural model, covers the combinations the properties deliberately leave out.

// File: rtl/dbg_rx_pkg.sv
// Shared definitions for the debug receive mailbox.
// Assumes: the flag word layout is fixed because both the host and core decode it.
package dbg_rx_pkg;
    localparam int STAT_W  = 3;
    localparam int RDY_BIT = 0;
    localparam int DL_BIT  = 1;
    localparam int OVF_BIT = 2;

    // Packed so that rdy lands on bit 0, dl on bit 1, ovf on bit 2.
    typedef struct packed {
        logic ovf;
        logic dl;
        logic rdy;
    } rx_flags_t;
endpackage

// File: rtl/rx_data_reg.sv
// Single-word storage for the mailbox.
// Assumes: load is a one-cycle qualifier decided by the flag controller.
module rx_data_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] word_q;

    // Capture the incoming word when the controller accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= din;
    end

    assign dout = word_q;
endmodule

// File: rtl/rx_flag_ctrl.sv
// Ready, download and overflow flag controller.
// Decides whether a write is accepted and maintains the three flags.
// Assumes: all strobes are single-cycle and synchronous to clk.
module rx_flag_ctrl
    import dbg_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_ok,
    input  logic      wr_dl,
    input  logic      dl_clr,
    input  logic      rd,
    input  logic      ovf_clr,
    output logic      load,
    output rx_flags_t flags
);
    rx_flags_t flags_q, flags_d;
    logic      streaming;
    logic      occupied;
    logic      lost;

    // Classify the incoming write against the current state.
    always_comb begin
        streaming = flags_q.dl | wr_dl;
        occupied  = flags_q.rdy & ~rd;
        load      = wr_ok & (~occupied | streaming);
        lost      = wr_ok & occupied & streaming;
    end

    // Next-state logic for the three flags.
    always_comb begin
        flags_d = flags_q;
        if (load)    flags_d.rdy = 1'b1;
        else if (rd) flags_d.rdy = 1'b0;
        if (dl_clr)              flags_d.dl = 1'b0;
        else if (wr_ok && wr_dl) flags_d.dl = 1'b1;
        if (lost)         flags_d.ovf = 1'b1;
        else if (ovf_clr) flags_d.ovf = 1'b0;
    end

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/dbg_rx_mailbox.sv
// Debug receive mailbox top: host write port, core read port, shared flags.
// Assumes: single clock domain; scan and synchronisation handled upstream.
module dbg_rx_mailbox
    import dbg_rx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_valid,
    input  logic              host_dl,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_dl_clr,
    output logic [STAT_W-1:0] host_status,
    input  logic              core_rd,
    output logic [DATA_W-1:0] core_rdata,
    output logic [STAT_W-1:0] core_status,
    input  logic              core_ovf_clr
);
    logic      wr_ok;
    logic      load;
    rx_flags_t flags;

    // A write only counts when it is qualified as valid.
    assign wr_ok = host_wr & host_valid;

    rx_flag_ctrl u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok),
        .wr_dl   (host_dl),
        .dl_clr  (host_dl_clr),
        .rd      (core_rd),
        .ovf_clr (core_ovf_clr),
        .load    (load),
        .flags   (flags)
    );

    rx_data_reg #(.DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (host_wdata),
        .dout  (core_rdata)
    );

    // Both sides see the same flag word.
    assign host_status = flags;
    assign core_status = flags;
endmodule

// File: rtl/dbg_rx_mailbox_chk.sv
// Property checker for the debug receive mailbox, attached by bind.
// Assumes: inputs are known after reset is released.
module dbg_rx_mailbox_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_valid,
    input logic              host_dl,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_dl_clr,
    input logic [2:0]        host_status,
    input logic              core_rd,
    input logic [DATA_W-1:0] core_rdata,
    input logic              core_ovf_clr
);
    logic wv;
    assign wv = host_wr & host_valid;

    // R1
    load_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wv && !host_status[0] |=> host_status[0] && core_rdata == $past(host_wdata));
    // R2
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd && !wv |=> !host_status[0]);
    // R3
    invalid_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && !host_valid && !core_rd && !host_dl_clr && !core_ovf_clr
        |=> $stable(host_status) && $stable(core_rdata));
    // R4
    polled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wv && host_status[0] && !core_rd && !host_status[1] && !host_dl && !core_ovf_clr
        |=> $stable(core_rdata) && $stable(host_status[2]));
    // R5
    dl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wv && host_dl && !host_dl_clr |=> host_status[1]);
    // R5
    dl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_dl_clr |=> !host_status[1]);
    // R6
    stream_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wv && host_status[0] && !core_rd && (host_status[1] || host_dl)
        |=> host_status[2] && core_rdata == $past(host_wdata));
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_status[2] && !core_ovf_clr |=> host_status[2]);
    // R8
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wv && host_status[0] && core_rd && !host_status[2]
        |=> host_status[0] && !host_status[2] && core_rdata == $past(host_wdata));
endmodule

bind dbg_rx_mailbox dbg_rx_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_valid   (host_valid),
    .host_dl      (host_dl),
    .host_wdata   (host_wdata),
    .host_dl_clr  (host_dl_clr),
    .host_status  (host_status),
    .core_rd      (core_rd),
    .core_rdata   (core_rdata),
    .core_ovf_clr (core_ovf_clr)
);

// File: tb/dbg_rx_mailbox_tb.sv
// Bench: behavioural reference model compared against the design every clock.
module dbg_rx_mailbox_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0, host_valid = 1'b0, host_dl = 1'b0, host_dl_clr = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic          core_rd = 1'b0, core_ovf_clr = 1'b0;
    logic [2:0]    host_status, core_status;
    logic [DW-1:0] core_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state
    int            m_rdy = 0, m_dl = 0, m_ovf = 0;
    logic [DW-1:0] m_data = '0;
    logic [DW-1:0] streamed[$];

    always #2 clk = ~clk;  // 250 MHz

    dbg_rx_mailbox #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_valid(host_valid), .host_dl(host_dl),
        .host_wdata(host_wdata), .host_dl_clr(host_dl_clr), .host_status(host_status),
        .core_rd(core_rd), .core_rdata(core_rdata), .core_status(core_status),
        .core_ovf_clr(core_ovf_clr)
    );

    task automatic check(input string req, input string what, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] m_status();
        return {m_ovf[0], m_dl[0], m_rdy[0]};
    endfunction

    // Compare the design's state against the model (R9 layout on both views).
    task automatic compare(input string req);
        check(req, "host_status", {29'd0, host_status}, {29'd0, m_status()});
        check(req, "core_status", {29'd0, core_status}, {29'd0, m_status()});
        check(req, "core_rdata", core_rdata, m_data);
    endtask

    // One clock: drive at negedge, advance model, compare after the edge.
    task automatic cyc(input logic wr, input logic vld, input logic dl, input logic [DW-1:0] d,
                       input logic dlc, input logic rd, input logic oc, input string req);
        int wv, strm, occ, ld, lost;
        host_wr = wr; host_valid = vld; host_dl = dl; host_wdata = d;
        host_dl_clr = dlc; core_rd = rd; core_ovf_clr = oc;
        #0;
        if (rd) check(req, "read returns old word", core_rdata, m_data);
        wv   = (wr && vld) ? 1 : 0;
        strm = (m_dl != 0 || dl) ? 1 : 0;
        occ  = (m_rdy != 0 && !rd) ? 1 : 0;
        ld   = (wv != 0 && (occ == 0 || strm != 0)) ? 1 : 0;
        lost = (wv != 0 && occ != 0 && strm != 0) ? 1 : 0;
        if (ld != 0) begin
            m_data = d;
            if (strm != 0) streamed.push_back(d);
        end
        if (ld != 0) m_rdy = 1; else if (rd) m_rdy = 0;
        if (dlc) m_dl = 0; else if (wv != 0 && dl) m_dl = 1;
        if (lost != 0) m_ovf = 1; else if (oc) m_ovf = 0;
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R9");  // reset state
        // R1 polled write into empty mailbox
        cyc(1, 1, 0, 32'hA0A0_0001, 0, 0, 0, "R1");
        // R4 polled write while occupied is dropped
        cyc(1, 1, 0, 32'hB0B0_0002, 0, 0, 0, "R4");
        // R2 read clears ready
        cyc(0, 0, 0, 32'h0, 0, 1, 0, "R2");
        // R3 invalid write does nothing
        cyc(1, 0, 1, 32'hC0C0_0003, 0, 0, 0, "R3");
        cyc(0, 0, 0, 32'h0, 0, 1, 0, "R2");  // read with nothing waiting
        // R8 collision of read and write
        cyc(1, 1, 0, 32'hD0D0_0004, 0, 0, 0, "R1");
        cyc(1, 1, 0, 32'hE0E0_0005, 0, 1, 0, "R8");
        cyc(0, 0, 0, 32'h0, 0, 1, 0, "R2");
        // R5/R6 streaming with overflow
        cyc(1, 1, 1, 32'hF0F0_0006, 0, 0, 0, "R5");
        cyc(1, 1, 1, 32'h1111_0007, 0, 0, 0, "R6");
        // R7 sticky across idle, set beats clear
        cyc(0, 0, 0, 32'h0, 0, 0, 0, "R7");
        cyc(1, 1, 1, 32'h2222_0008, 0, 0, 1, "R7");
        cyc(0, 0, 0, 32'h0, 0, 0, 1, "R7");
        // R6 stored download flag alone selects streaming
        cyc(1, 1, 0, 32'h3333_0009, 0, 0, 0, "R6");
        cyc(0, 0, 0, 32'h0, 0, 0, 1, "R7");
        // R5 streaming reads, then clear beats a same-cycle setting write
        for (int i = 0; i < 6; i++) begin
            cyc(0, 0, 0, 32'h0, 0, 1, 0, "R2");
            cyc(1, 1, 1, 32'h4000_0000 + i, 0, 0, 0, "R5");
        end
        cyc(1, 1, 1, 32'h5555_000A, 1, 1, 0, "R5");
        cyc(0, 0, 0, 32'h0, 0, 1, 0, "R2");
        // R4 back in polled mode after clear
        cyc(1, 1, 0, 32'h6666_000B, 0, 0, 0, "R1");
        cyc(1, 1, 0, 32'h7777_000C, 0, 0, 0, "R4");
        // Random mix of strobes
        for (int i = 0; i < 2000; i++) begin
            logic [6:0] r;
            r = 7'($urandom);
            cyc(r[0], r[1], r[2] & r[5], $urandom, r[3] & r[4] & r[6], r[4],
                r[5] & r[6], "R6");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule